// File: doc/BRIEF.md
# External Interrupt Trigger Conditioner

This block takes up to six asynchronous interrupt pins from outside the chip and turns each one into a clean, masked request. Each pin first passes through a two-stage synchroniser. It is then qualified by its own trigger mode: active-high level, active-low level, rising edge, falling edge, or both edges. In the edge modes the event is held in a sticky flag. The flag stays set until software drops it by writing a one to that line's clear bit. In the level modes the request simply tracks the synchronised pin, with no storage.

Software sets each line through a byte-wide slot in one of two 32-bit configuration words. Lines 0 to 3 sit in word 0, and lines 4 and above sit in word 1, at slot (line mod 4). The requests leave the block in one of two ways. In the default cascaded build, line i drives bit `INT_BASE + i` of a vector of internal interrupt sources. A line's mask therefore gates both the external line and the internal source fed by it. In a non-cascaded build the requests appear on one direct output per line.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset every line reads back as active-low level with the mask bit clear. Word 0 reads 0x01010101 and word 1 reads 0x00000101. All request outputs are 0.
- R2: Each line's slot byte has this layout: bit 0 is level-select, bit 1 is polarity, bit 2 is both-edge, bit 3 is mask and bit 4 is a write-one clear. The clear bit always reads 0. Slots with no line behind them read 0 and ignore writes.
- R3: In a level mode (level-select = 1), the request equals mask AND (synchronised pin == polarity). A pin change reaches the request after the second rising clock edge.
- R4: With level-select = 0 and both-edge = 0, a rising edge (polarity = 1) or a falling edge (polarity = 0) sets the sticky flag. The request rises after the third clock edge following the pin change.
- R5: With level-select = 0 and both-edge = 1, either edge sets the flag, whatever the polarity.
- R6: A latched flag stays set until a register write carries a 1 in that line's clear bit. The write drops the flag at its own clock edge.
- R7: When a clear write and a newly detected edge fall on the same clock edge, the flag stays set.
- R8: The mask gates only the request. An edge seen while masked is still latched and appears when the line is unmasked.
- R9: While level-select is 1, the flag is held at 0. Level-select overrides both-edge.
- R10: With cascading enabled, line i drives casc_o[INT_BASE+i]. All other internal bits are 0, and the direct outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_LINES | Raw asynchronous interrupt pins |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_idx_i | input | IDX_W | Configuration word selected for writing |
| wr_data_i | input | 32 | Configuration write data |
| rd_idx_i | input | IDX_W | Configuration word selected for reading |
| rd_data_o | output | 32 | Read-back of the selected word (combinational) |
| irq_o | output | NUM_LINES | Direct per-line requests (non-cascaded build) |
| casc_o | output | INT_W | Requests mapped onto the internal source vector |

## Verification
The assertions assume that the pins are low while reset is applied. A pin that is high when reset is released would be seen as a rising edge. They also assume that every write sets all of a word's slots at once. The bench keeps the pins low through reset and always builds full words from its own copy of the configuration. It holds each pin pattern for several cycles, so that at most one transition per line passes through the synchroniser between checks. Random configuration words, including level-select combined with both-edge, are mixed with directed cases for latency, set-versus-clear collision and masked latching.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int SLOT_W        = 8;
    localparam int SLOTS_PER_REG = 4;
    localparam int CLR_BIT       = 4;

    // bit 0 level-select, bit 1 polarity, bit 2 both-edge, bit 3 mask
    typedef struct packed {
        logic mask;
        logic both;
        logic pol;
        logic lvl;
    } line_cfg_t;

    localparam line_cfg_t CFG_RESET = '{mask: 1'b0, both: 1'b0, pol: 1'b0, lvl: 1'b1};

    // edge qualifier for one line given current and previous synchronised value
    function automatic logic edge_hit(line_cfg_t c, logic cur, logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (c.lvl)       return 1'b0;
        else if (c.both) return rise | fall;
        else if (c.pol)  return rise;
        else             return fall;
    endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/extirq_line.sv
module extirq_line
    import extirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      s_i,
    input  line_cfg_t cfg_i,
    input  logic      clr_i,
    output logic      req_o
);

    typedef struct packed {
        logic prev;
        logic flag;
    } line_st_t;

    line_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d      = st_q;
        hit       = edge_hit(cfg_i, s_i, st_q.prev);
        st_d.prev = s_i;
        if (cfg_i.lvl)  st_d.flag = 1'b0;
        else if (hit)   st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
        req_o = cfg_i.mask & (cfg_i.lvl ? (s_i == cfg_i.pol) : st_q.flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !cfg_i.lvl && !clr_i) |=> st_q.flag);

    // R6
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !cfg_i.lvl && (s_i == st_q.prev)) |=> !st_q.flag);

    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(s_i != st_q.prev));

    // R9
    level_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_i.lvl) && cfg_i.lvl) |-> !st_q.flag);

endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_LINES = 6,
    parameter int INT_W     = 32,
    parameter int INT_BASE  = 24,
    parameter bit CASCADE   = 1'b1,
    localparam int NREG     = (NUM_LINES + SLOTS_PER_REG - 1) / SLOTS_PER_REG,
    localparam int IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_i,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [31:0]          wr_data_i,
    input  logic [IDX_W-1:0]     rd_idx_i,
    output logic [31:0]          rd_data_o,
    output logic [NUM_LINES-1:0] irq_o,
    output logic [INT_W-1:0]     casc_o
);

    typedef struct packed {
        line_cfg_t [NUM_LINES-1:0] cfg;
    } regs_t;

    regs_t                regs_d, regs_q;
    logic [NUM_LINES-1:0] clr;
    logic [NUM_LINES-1:0] s_lines;
    logic [NUM_LINES-1:0] line_req;
    logic [NUM_LINES-1:0] mask_vec;

    always_comb begin
        regs_d = regs_q;
        clr    = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (wr_en_i && (wr_idx_i == IDX_W'(i / SLOTS_PER_REG))) begin
                regs_d.cfg[i] = line_cfg_t'(wr_data_i[(i % SLOTS_PER_REG)*SLOT_W +: 4]);
                clr[i]        = wr_data_i[(i % SLOTS_PER_REG)*SLOT_W + CLR_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= {NUM_LINES{CFG_RESET}};
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (rd_idx_i == IDX_W'(i / SLOTS_PER_REG))
                rd_data_o[(i % SLOTS_PER_REG)*SLOT_W +: 4] = regs_q.cfg[i];
        end
    end

    extirq_sync #(.W(NUM_LINES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (s_lines)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign mask_vec[g] = regs_q.cfg[g].mask;
        extirq_line i_line (
            .clk   (clk),
            .rst_n (rst_n),
            .s_i   (s_lines[g]),
            .cfg_i (regs_q.cfg[g]),
            .clr_i (clr[g]),
            .req_o (line_req[g])
        );
    end

    if (CASCADE) begin : g_casc
        assign casc_o = INT_W'(line_req) << INT_BASE;
        assign irq_o  = '0;
    end else begin : g_direct
        assign casc_o = '0;
        assign irq_o  = line_req;
    end

    // R8
    no_unmasked_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_req & ~mask_vec) == '0);

    // R2
    clr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[CLR_BIT] == 1'b0) && (rd_data_o[SLOT_W + CLR_BIT] == 1'b0));

endmodule

// File: tb/test_extirq_ctrl.sv
module test_extirq_ctrl;

    localparam int N    = 6;
    localparam int BASE = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] pin = '0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [0:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [N-1:0] irq;
    logic [31:0] casc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [3:0] cfg_m [N];   // {mask, both, pol, lvl}
    logic       flag_m[N];
    logic       pin_m [N];

    always #4 clk = ~clk;

    extirq_ctrl i_extirq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .irq_o(irq), .casc_o(casc)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_m(int idx);
        logic [31:0] w = '0;
        for (int i = 0; i < N; i++)
            if (i / 4 == idx) w[(i % 4)*8 +: 4] = cfg_m[i];
        return w;
    endfunction

    function automatic logic [31:0] exp_casc();
        logic [31:0] v = '0;
        for (int i = 0; i < N; i++) begin
            if (cfg_m[i][0]) v[BASE+i] = cfg_m[i][3] & (pin_m[i] == cfg_m[i][1]);
            else             v[BASE+i] = cfg_m[i][3] & flag_m[i];
        end
        return v;
    endfunction

    task automatic wr(int idx, logic [N-1:0] clrv, logic [31:0] extra);
        logic [31:0] d = word_m(idx) | extra;
        for (int i = 0; i < N; i++)
            if (i / 4 == idx && clrv[i]) d[(i % 4)*8 + 4] = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 1'(idx); wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < N; i++)
            if (i / 4 == idx && (cfg_m[i][0] || clrv[i])) flag_m[i] = 1'b0;
    endtask

    task automatic set_pins(logic [N-1:0] v);
        @(negedge clk);
        pin = v;
        for (int i = 0; i < N; i++) begin
            if (!cfg_m[i][0] && pin_m[i] != v[i]) begin
                if (cfg_m[i][2] || (cfg_m[i][1] == v[i])) flag_m[i] = 1'b1;
            end
            pin_m[i] = v[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_out(string req);
        chk(req, casc, exp_casc());
        chk({req, " direct"}, 32'(irq), 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < N; i++) begin cfg_m[i] = 4'b0001; flag_m[i] = 0; pin_m[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_idx = 0; #1 chk("R1 word0", rd_data, 32'h01010101);
        rd_idx = 1; #1 chk("R1 word1", rd_data, 32'h00000101);
        chk("R1 casc", casc, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 unused slots ignore writes, clear reads 0
        cfg_m[4] = 4'b1010; cfg_m[5] = 4'b1100;
        wr(1, 6'b110000, 32'h1F1F0000);
        rd_idx = 1; #1 chk("R2 word1 readback", rd_data, 32'h00000C0A);

        // R3 level high on line 1, latency two edges
        cfg_m[1] = 4'b1011; wr(0, '0, '0);
        @(negedge clk); pin[1] = 1'b1; pin_m[1] = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R3 level after 1 edge", 32'(casc[BASE+1]), 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R3 level after 2 edges", 32'(casc[BASE+1]), 32'h1);
        set_pins(6'b000000);
        chk_out("R3 level high drop");

        // R4 rising edge on line 0, latency three edges
        cfg_m[0] = 4'b1010; wr(0, '0, '0);
        @(negedge clk); pin[0] = 1'b1; pin_m[0] = 1'b1; flag_m[0] = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R4 rise after 2 edges", 32'(casc[BASE+0]), 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R4 rise after 3 edges", 32'(casc[BASE+0]), 32'h1);
        set_pins(6'b000000);
        chk_out("R6 flag held after pin falls");
        wr(0, 6'b000001, '0);
        chk_out("R6 clear drops flag");

        // R7 clear colliding with a new edge
        @(negedge clk); pin[0] = 1'b1; pin_m[0] = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        wr_en = 1'b1; wr_idx = 0; wr_data = word_m(0) | 32'h10;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        flag_m[0] = 1'b1;
        chk("R7 set wins over clear", 32'(casc[BASE+0]), 32'h1);
        wr(0, 6'b000001, '0);
        set_pins(6'b000000);

        // R8 masked edge latched, appears on unmask (falling, line 2)
        cfg_m[2] = 4'b0000; wr(0, '0, '0);
        set_pins(6'b000100);
        set_pins(6'b000000);
        chk_out("R8 masked no request");
        cfg_m[2] = 4'b1000; wr(0, '0, '0);
        chk_out("R8 latched edge on unmask");
        chk("R8 line2 high", 32'(casc[BASE+2]), 32'h1);

        // R5 both edges on line 3
        cfg_m[3] = 4'b1100; wr(0, '0, '0);
        set_pins(6'b001000);
        chk("R5 both rise", 32'(casc[BASE+3]), 32'h1);
        wr(0, 6'b001000, '0);
        set_pins(6'b000000);
        chk("R5 both fall", 32'(casc[BASE+3]), 32'h1);

        // R9 level overrides both-edge and clears flag
        cfg_m[3] = 4'b1101; wr(0, '0, '0);
        @(negedge clk);
        chk_out("R9 level low overrides both-edge");
        cfg_m[3] = 4'b1100; wr(0, '0, '0);
        @(negedge clk);
        chk_out("R9 flag cleared by level mode");

        // R10 random mix, cascaded mapping
        for (int it = 0; it < 300; it++) begin
            int idx = int'($urandom_range(1, 0));
            for (int i = 0; i < N; i++)
                if (i / 4 == idx) cfg_m[i] = 4'($urandom);
            wr(idx, 6'($urandom), '0);
            @(negedge clk);
            chk_out("R10 after write");
            set_pins(6'($urandom));
            chk_out("R10 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule